// File: doc/BRIEF.md
# Multi-Mode Control Timer

This block is one synchronous timer channel for control logic. A trigger input (S), a clear input (R) and a time value go in, and one output (Q) comes out. A 3-bit mode input picks one of five behaviours:

- delay-on;
- latched delay-on;
- delay-off;
- bounded pulse;
- stretched pulse.

Timing advances only on clock cycles where an external one-cycle time-base tick is high. The tick is normally a 1 ms strobe.

The time value arrives as four separate fields: hours, minutes, seconds and milliseconds. The block turns these fields into a tick count. It reads that count only when an interval starts. While an interval runs, two outputs report the elapsed and remaining tick counts.

All inputs are sampled on the rising clock edge. Q is a register, so Q reflects the inputs seen at an edge just after that same edge. In the text below, "the edge where X" means the clock edge at which X is sampled. After reset, Q, elapsed and remaining are all zero. The mode input is expected to stay stable while an interval is running. Mode codes 5 to 7 behave as mode 0.

Top module: `ctrl_timer`

## Requirements
- R1: After reset, and whenever no interval is running or held, Q is 0 and both elapsed and remaining read 0.
- R2: Mode 0 (delay-on) is level-started. The interval starts at an edge where S is 1. If S stays 1 until the interval completes, Q becomes 1 at the completing edge and stays 1 while S stays 1. If S is 0 at any edge, the interval is abandoned and Q is 0 after that edge.
- R3: Mode 1 (latched delay-on) starts only on a rising edge of S. Timing continues even if S returns to 0. Q becomes 1 when the interval completes and stays 1 until R is asserted.
- R4: Mode 2 (delay-off) gives Q = 1 after any edge where S is 1, and no timing happens while S is 1. A falling edge of S starts the interval, and Q drops to 0 when it completes. If S returns to 1 during the interval, the interval is abandoned and Q stays 1.
- R5: Mode 3 (bounded pulse) sets Q to 1 on a rising edge of S. Q returns to 0 when the interval completes or at the first edge where S is 0, whichever comes first. Q stays 0 while S stays high after completion.
- R6: Mode 4 (stretched pulse) sets Q to 1 on a rising edge of S and keeps it at 1 for the full interval, even if S falls. A rising edge of S during a pulse does not retrigger the pulse.
- R7: R=1 at an edge stops any interval and gives Q = 0, and R wins over S at the same edge. After R is released, the edge-started modes (1, 3, 4) need a new rising edge of S; a held S starts nothing.
- R8: The interval length in ticks is ((hours*60 + minutes)*60 + seconds)*1000 + milliseconds, multiplied by TICKS_PER_MS (default 1). At the start edge, elapsed is 0 and remaining equals that length.
- R9: The time value is captured at the start edge. Changing the fields during an interval does not change when it completes or what remaining reports.
- R10: Elapsed increases by one at each edge where the tick input is 1 during an interval. An interval of length L completes at the L-th tick after the start edge; a tick at the start edge itself is not counted. A zero-length interval completes at the first tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_in | input | 1 | One-cycle time-base strobe |
| trig_in | input | 1 | S: trigger or enable |
| clr_in | input | 1 | R: clear, highest priority |
| mode_in | input | 3 | Behaviour select (0 to 4) |
| tv_hours | input | HR_W (5) | Hours field of the time value |
| tv_minutes | input | MIN_W (6) | Minutes field |
| tv_seconds | input | SEC_W (6) | Seconds field |
| tv_millis | input | MS_W (10) | Milliseconds field |
| q_out | output | 1 | Q output |
| elapsed | output | CNT_W (32) | Ticks counted in the current interval |
| remaining | output | CNT_W (32) | Ticks left while an interval is running, else 0 |

## Verification
The main function is driven by a cycle-by-cycle S and R sequence in each mode, using a two-tick interval. Each sequence places S falls before completion, after completion and during a running interval. These cases tell apart the level-started modes from the edge-started ones, and the modes that keep running after S falls from those that stop. A rising S during a stretched pulse shows that a pulse does not retrigger. R held together with a rising S shows that a held S does not restart a timer after R is released. Separate patterns cover:

- a multi-field time value, which checks the conversion weights;
- a time value changed mid-interval, which checks the capture at the start edge;
- a tick held low, which checks that counting advances only on ticks;
- an all-zero time value.

// File: rtl/ctrl_timer_pkg.sv
// Package: shared types and constants for the control timer.
// Assumes: mode codes 0..4 are the only defined behaviours.
package ctrl_timer_pkg;

    typedef enum logic [2:0] {
        MODE_DELAY_ON  = 3'd0,
        MODE_LATCH_ON  = 3'd1,
        MODE_DELAY_OFF = 3'd2,
        MODE_PULSE     = 3'd3,
        MODE_PULSE_EXT = 3'd4
    } tmr_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_TIMING = 2'd1,
        PH_DONE   = 2'd2
    } tmr_phase_e;

    localparam int MIN_PER_HR  = 60;
    localparam int SEC_PER_MIN = 60;
    localparam int MS_PER_SEC  = 1000;

endpackage

// File: rtl/ctrl_timer_preset.sv
// Module: converts the hour/minute/second/millisecond fields into a tick count.
// Assumes: the result fits in CNT_W bits (larger values wrap); purely combinational.
module ctrl_timer_preset
    import ctrl_timer_pkg::*;
#(
    parameter int HR_W         = 5,
    parameter int MIN_W        = 6,
    parameter int SEC_W        = 6,
    parameter int MS_W         = 10,
    parameter int CNT_W        = 32,
    parameter int TICKS_PER_MS = 1
) (
    input  logic [HR_W-1:0]  hours,
    input  logic [MIN_W-1:0] minutes,
    input  logic [SEC_W-1:0] seconds,
    input  logic [MS_W-1:0]  millis,
    output logic [CNT_W-1:0] ticks
);

    localparam logic [CNT_W-1:0] K_MIN = CNT_W'(MIN_PER_HR);
    localparam logic [CNT_W-1:0] K_SEC = CNT_W'(SEC_PER_MIN);
    localparam logic [CNT_W-1:0] K_MS  = CNT_W'(MS_PER_SEC);
    localparam logic [CNT_W-1:0] K_TPM = CNT_W'(TICKS_PER_MS);

    logic [CNT_W-1:0] min_total;
    logic [CNT_W-1:0] sec_total;
    logic [CNT_W-1:0] ms_total;

    // Purpose: fold the fields into milliseconds, one unit at a time.
    always_comb begin
        min_total = CNT_W'(hours) * K_MIN + CNT_W'(minutes);
        sec_total = min_total * K_SEC + CNT_W'(seconds);
        ms_total  = sec_total * K_MS + CNT_W'(millis);
    end

    // A 1 ms time base needs no final scaling multiplier.
    generate
        if (TICKS_PER_MS == 1) begin : g_unit_tick
            assign ticks = ms_total;
        end else begin : g_scaled_tick
            assign ticks = ms_total * K_TPM;
        end
    endgenerate

endmodule

// File: rtl/ctrl_timer_edge.sv
// Module: registers the trigger level and flags its rising and falling edges.
// Assumes: the trigger is already synchronous to clk; reset sees it as low.
module ctrl_timer_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic lvl_q;

    // Purpose: keep the previous sampled level of the trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl;
        end
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;

endmodule

// File: rtl/ctrl_timer_count.sv
// Module: elapsed-tick counter plus the interval length captured at start.
// Assumes: clear beats load, and load beats advance; the sequencer drives all three.
module ctrl_timer_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic             advance,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] limit,
    output logic             at_limit
);

    logic [CNT_W:0] cnt_inc;

    // Purpose: hold the elapsed count and capture the length at each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            limit <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (load) begin
            cnt   <= '0;
            limit <= preset;
        end else if (advance) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Purpose: tell whether the next tick completes the interval (one extra bit avoids wrap).
    always_comb begin
        cnt_inc  = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
        at_limit = (cnt_inc >= {1'b0, limit});
    end

endmodule

// File: rtl/ctrl_timer_seq.sv
// Module: phase sequencer and Q register for the five timer behaviours.
// Assumes: the mode is stable during an interval; codes outside 0..4 act as delay-on.
module ctrl_timer_seq
    import ctrl_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tmr_mode_e  mode,
    input  logic       s_lvl,
    input  logic       s_rise,
    input  logic       s_fall,
    input  logic       clr,
    input  logic       tick,
    input  logic       at_limit,
    output tmr_phase_e phase,
    output logic       q,
    output logic       load,
    output logic       clear,
    output logic       advance
);

    tmr_phase_e nxt;
    logic       q_nxt;
    logic       expire;

    // Purpose: next phase for the selected behaviour; clear wins over everything.
    always_comb begin
        nxt    = phase;
        expire = (phase == PH_TIMING) && tick && at_limit;
        case (mode)
            MODE_LATCH_ON: begin
                if (phase == PH_IDLE && s_rise)  nxt = PH_TIMING;
                else if (expire)                 nxt = PH_DONE;
            end
            MODE_DELAY_OFF: begin
                if (s_lvl)                       nxt = PH_IDLE;
                else if (phase == PH_IDLE && s_fall) nxt = PH_TIMING;
                else if (expire)                 nxt = PH_IDLE;
                else if (phase == PH_DONE)       nxt = PH_IDLE;
            end
            MODE_PULSE: begin
                if (phase == PH_IDLE) begin
                    if (s_rise) nxt = PH_TIMING;
                end else if (!s_lvl || expire) begin
                    nxt = PH_IDLE;
                end
            end
            MODE_PULSE_EXT: begin
                if (phase == PH_IDLE && s_rise)  nxt = PH_TIMING;
                else if (expire)                 nxt = PH_IDLE;
                else if (phase == PH_DONE)       nxt = PH_IDLE;
            end
            default: begin
                if (!s_lvl)                      nxt = PH_IDLE;
                else if (phase == PH_IDLE)       nxt = PH_TIMING;
                else if (expire)                 nxt = PH_DONE;
            end
        endcase
        if (clr) nxt = PH_IDLE;
    end

    // Purpose: Q value that follows the next phase (delay-off also follows S).
    always_comb begin
        case (mode)
            MODE_LATCH_ON:  q_nxt = (nxt == PH_DONE);
            MODE_DELAY_OFF: q_nxt = s_lvl || (nxt == PH_TIMING);
            MODE_PULSE:     q_nxt = (nxt == PH_TIMING);
            MODE_PULSE_EXT: q_nxt = (nxt == PH_TIMING);
            default:        q_nxt = (nxt == PH_DONE);
        endcase
        if (clr) q_nxt = 1'b0;
    end

    // Purpose: counter controls derived from the phase change.
    always_comb begin
        clear   = clr || (nxt == PH_IDLE);
        load    = (phase != PH_TIMING) && (nxt == PH_TIMING);
        advance = (phase == PH_TIMING) && tick && (nxt != PH_IDLE);
    end

    // Purpose: phase and Q registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            q     <= 1'b0;
        end else begin
            phase <= nxt;
            q     <= q_nxt;
        end
    end

endmodule

// File: rtl/ctrl_timer.sv
// Module: top of the multi-mode control timer; wires edge detect, preset
// conversion, counter and sequencer, and forms the remaining-time report.
// Assumes: all inputs are synchronous to clk; tick_in is high for one cycle per time unit.
module ctrl_timer
    import ctrl_timer_pkg::*;
#(
    parameter int HR_W         = 5,
    parameter int MIN_W        = 6,
    parameter int SEC_W        = 6,
    parameter int MS_W         = 10,
    parameter int CNT_W        = 32,
    parameter int TICKS_PER_MS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic             trig_in,
    input  logic             clr_in,
    input  logic [2:0]       mode_in,
    input  logic [HR_W-1:0]  tv_hours,
    input  logic [MIN_W-1:0] tv_minutes,
    input  logic [SEC_W-1:0] tv_seconds,
    input  logic [MS_W-1:0]  tv_millis,
    output logic             q_out,
    output logic [CNT_W-1:0] elapsed,
    output logic [CNT_W-1:0] remaining
);

    logic             s_rise;
    logic             s_fall;
    logic [CNT_W-1:0] preset_ticks;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             at_limit;
    logic             load;
    logic             clear;
    logic             advance;
    tmr_phase_e       phase;
    tmr_mode_e        mode;

    assign mode = tmr_mode_e'(mode_in);

    ctrl_timer_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (trig_in),
        .rise (s_rise),
        .fall (s_fall)
    );

    ctrl_timer_preset #(
        .HR_W        (HR_W),
        .MIN_W       (MIN_W),
        .SEC_W       (SEC_W),
        .MS_W        (MS_W),
        .CNT_W       (CNT_W),
        .TICKS_PER_MS(TICKS_PER_MS)
    ) u_preset (
        .hours  (tv_hours),
        .minutes(tv_minutes),
        .seconds(tv_seconds),
        .millis (tv_millis),
        .ticks  (preset_ticks)
    );

    ctrl_timer_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .load    (load),
        .advance (advance),
        .preset  (preset_ticks),
        .cnt     (cnt),
        .limit   (limit),
        .at_limit(at_limit)
    );

    ctrl_timer_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .s_lvl   (trig_in),
        .s_rise  (s_rise),
        .s_fall  (s_fall),
        .clr     (clr_in),
        .tick    (tick_in),
        .at_limit(at_limit),
        .phase   (phase),
        .q       (q_out),
        .load    (load),
        .clear   (clear),
        .advance (advance)
    );

    // Purpose: report ticks left only while an interval is running.
    always_comb begin
        elapsed   = cnt;
        remaining = (phase == PH_TIMING) ? (limit - cnt) : '0;
    end

endmodule

// File: rtl/ctrl_timer_chk.sv
// Module: property checker for ctrl_timer, attached by bind below.
// Assumes: observes only top-level ports.
module ctrl_timer_chk
    import ctrl_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_in,
    input logic             trig_in,
    input logic             clr_in,
    input logic [2:0]       mode_in,
    input logic             q_out,
    input logic [CNT_W-1:0] elapsed
);

    // Delay-on: S low at an edge means Q low afterwards.
    assert_delay_on_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_in == MODE_DELAY_ON && !trig_in) |=> !q_out);

    // Latched delay-on: once Q is high it stays high until clear.
    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_in == MODE_LATCH_ON && q_out && !clr_in && $stable(mode_in)) |=> q_out);

    // Delay-off: S high (and no clear) gives Q high.
    assert_delay_off_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_in == MODE_DELAY_OFF && trig_in && !clr_in) |=> q_out);

    // Bounded pulse: S low ends the pulse.
    assert_pulse_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_in == MODE_PULSE && !trig_in) |=> !q_out);

    // Clear forces Q low.
    assert_clear_q_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_in |=> !q_out);

    // No tick and no input change: the elapsed count does not move.
    assert_hold_without_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_in && !clr_in && $stable(trig_in) && $stable(mode_in)) |=> $stable(elapsed));

endmodule

bind ctrl_timer ctrl_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_in(tick_in),
    .trig_in(trig_in),
    .clr_in (clr_in),
    .mode_in(mode_in),
    .q_out  (q_out),
    .elapsed(elapsed)
);

// File: tb/ctrl_timer_tb.sv
`timescale 1ns/1ps
module ctrl_timer_tb;

    localparam int CNT_W = 32;
    localparam int NVEC  = 46;

    // Each entry: {mode[2:0], clear, trigger, expected Q after the edge}; interval = 2 ticks.
    localparam logic [5:0] VEC [0:NVEC-1] = '{
        6'b000_1_0_0, 6'b000_0_1_0, 6'b000_0_1_0, 6'b000_0_1_1, 6'b000_0_1_1,
        6'b000_0_0_0, 6'b000_0_1_0, 6'b000_0_1_0, 6'b000_0_0_0,
        6'b001_1_0_0, 6'b001_0_1_0, 6'b001_0_0_0, 6'b001_0_0_1, 6'b001_0_0_1,
        6'b001_1_0_0, 6'b001_0_0_0,
        6'b010_1_0_0, 6'b010_0_1_1, 6'b010_0_1_1, 6'b010_0_0_1, 6'b010_0_0_1,
        6'b010_0_0_0, 6'b010_0_1_1, 6'b010_0_0_1, 6'b010_0_1_1, 6'b010_0_1_1,
        6'b010_0_0_1, 6'b010_0_0_1, 6'b010_0_0_0,
        6'b011_1_0_0, 6'b011_0_1_1, 6'b011_0_1_1, 6'b011_0_1_0, 6'b011_0_1_0,
        6'b011_0_0_0, 6'b011_0_1_1, 6'b011_0_0_0,
        6'b100_1_0_0, 6'b100_0_1_1, 6'b100_0_0_1, 6'b100_0_0_0, 6'b100_0_1_1,
        6'b100_0_0_1, 6'b100_0_1_0, 6'b100_0_1_0, 6'b100_0_0_0
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_in = 1'b1;
    logic             trig_in = 1'b0;
    logic             clr_in = 1'b0;
    logic [2:0]       mode_in = 3'd0;
    logic [4:0]       tv_hours = '0;
    logic [5:0]       tv_minutes = '0;
    logic [5:0]       tv_seconds = '0;
    logic [9:0]       tv_millis = '0;
    logic             q_out;
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] remaining;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    ctrl_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (tick_in),
        .trig_in   (trig_in),
        .clr_in    (clr_in),
        .mode_in   (mode_in),
        .tv_hours  (tv_hours),
        .tv_minutes(tv_minutes),
        .tv_seconds(tv_seconds),
        .tv_millis (tv_millis),
        .q_out     (q_out),
        .elapsed   (elapsed),
        .remaining (remaining)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_tv(input int h, input int m, input int s, input int ms);
        tv_hours   = 5'(h);
        tv_minutes = 6'(m);
        tv_seconds = 6'(s);
        tv_millis  = 10'(ms);
    endtask

    function automatic string vec_tag(input logic [2:0] m, input logic r);
        if (r) return "R7";
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        // R1: reset state
        step();
        step();
        chk("R1 reset q", {63'd0, q_out}, 64'd0);
        chk("R1 reset elapsed", 64'(elapsed), 64'd0);
        chk("R1 reset remaining", 64'(remaining), 64'd0);
        rst_n = 1'b1;

        // Table walk over all five behaviours
        set_tv(0, 0, 0, 2);
        tick_in = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            mode_in = VEC[i][5:3];
            clr_in  = VEC[i][2];
            trig_in = VEC[i][1];
            step();
            chk(vec_tag(VEC[i][5:3], VEC[i][2]), {63'd0, q_out}, {63'd0, VEC[i][0]});
        end

        // R8: field weights; remaining at start edge equals the converted length
        mode_in = 3'd1; clr_in = 1'b1; trig_in = 1'b0; step();
        clr_in = 1'b0;
        set_tv(1, 2, 3, 4);
        trig_in = 1'b1; step();
        chk("R8 remaining at start", 64'(remaining), 64'd3723004);
        chk("R8 elapsed at start", 64'(elapsed), 64'd0);
        trig_in = 1'b0; step();
        chk("R8 elapsed one tick", 64'(elapsed), 64'd1);
        chk("R8 remaining one tick", 64'(remaining), 64'd3723003);
        clr_in = 1'b1; step();
        chk("R7 clear q", {63'd0, q_out}, 64'd0);
        chk("R1 idle remaining", 64'(remaining), 64'd0);
        chk("R1 idle elapsed", 64'(elapsed), 64'd0);
        clr_in = 1'b0;

        // R9: time value captured at start
        set_tv(0, 0, 0, 3);
        trig_in = 1'b1; step();
        set_tv(0, 0, 0, 50);
        step();
        chk("R9 remaining uses captured length", 64'(remaining), 64'd2);
        step();
        chk("R9 q before completion", {63'd0, q_out}, 64'd0);
        step();
        chk("R9 q at completion", {63'd0, q_out}, 64'd1);
        clr_in = 1'b1; trig_in = 1'b0; step();
        clr_in = 1'b0;

        // R10: counting only on ticks
        set_tv(0, 0, 0, 3);
        trig_in = 1'b1; step();
        tick_in = 1'b0;
        step(); step(); step();
        chk("R10 no tick no count", 64'(elapsed), 64'd0);
        tick_in = 1'b1; step();
        chk("R10 one tick", 64'(elapsed), 64'd1);
        tick_in = 1'b0; step();
        chk("R10 held count", 64'(elapsed), 64'd1);
        chk("R10 q still low", {63'd0, q_out}, 64'd0);
        tick_in = 1'b1;
        clr_in = 1'b1; trig_in = 1'b0; step();
        clr_in = 1'b0;

        // R10: zero-length interval completes on first tick
        set_tv(0, 0, 0, 0);
        trig_in = 1'b1; step();
        chk("R10 zero start q", {63'd0, q_out}, 64'd0);
        step();
        chk("R10 zero done q", {63'd0, q_out}, 64'd1);
        clr_in = 1'b1; trig_in = 1'b0; step();
        clr_in = 1'b0;

        // R7: clear beats a rising S; a held S does not restart a pulse
        mode_in = 3'd3;
        set_tv(0, 0, 0, 5);
        step();
        clr_in = 1'b1; trig_in = 1'b1; step();
        chk("R7 clear over S", {63'd0, q_out}, 64'd0);
        clr_in = 1'b0; step();
        chk("R7 held S no start", {63'd0, q_out}, 64'd0);
        step();
        chk("R7 held S still idle", {63'd0, q_out}, 64'd0);
        trig_in = 1'b0; step();
        trig_in = 1'b1; step();
        chk("R7 new edge starts pulse", {63'd0, q_out}, 64'd1);

        // R1: reset in mid-interval
        rst_n = 1'b0; step();
        chk("R1 mid reset q", {63'd0, q_out}, 64'd0);
        chk("R1 mid reset elapsed", 64'(elapsed), 64'd0);
        chk("R1 mid reset remaining", 64'(remaining), 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule